// File: doc/BRIEF.md
# Leaf Page Entry Access Checker

This block is the last stage of a page-table walk. It takes the final (leaf) entry that the walk fetched, together with three attributes of the access that caused the walk: whether the access is privileged, whether it is an instruction fetch or a data access, and whether it is a store. It then decides whether the translation may be installed or whether the access must fault.

One cycle after a check strobe, the block registers a verdict. The verdict is exactly one of four flags:

- success,
- a permission fault,
- a reference/change fault,
- an invalid-entry flag.

Alongside the verdict it registers the entry's 2-bit memory attribute and the physical page base. All of these outputs hold their values until the next strobe.

The walker pulses the strobe once the leaf entry is on `pte`. On the following cycle it reads the verdict: on success it loads the translation, and on any flag it raises the fault. Entry bits are numbered little-endian, so bit 63 is the most significant bit.

Top module: `pte_leaf_checker`

## Requirements
- R1: All result outputs update only on the clock edge that samples `chk_strobe` high. They are valid from the next cycle and keep their values, whatever the inputs do, until the next sampled strobe.
- R2: An entry whose valid bit (bit 63) or leaf bit (bit 62) is clear gives `res_invalid`. In that case `res_ok`, `res_perm_err` and `res_rc_err` all stay low.
- R3: When bit 3 (privileged-only page) is set and `acc_priv` is low, the result is `res_perm_err`. When `acc_priv` is high, bit 3 has no effect.
- R4: A data access (`acc_ifetch` low) is permitted when bit 1 (read/write) is set. It is also permitted when bit 2 (read) is set and `acc_store` is low. Otherwise it is refused.
- R5: An instruction fetch is permitted only when bit 0 (execute) is set and bit 5 (cache-inhibit) is clear.
- R6: The reference/change check passes when bit 8 (referenced) is set and either bit 7 (changed) is set or `acc_store` is low. A failed check that has a permitted access gives `res_rc_err`.
- R7: When both the permission check and the reference/change check fail, only `res_perm_err` is raised.
- R8: After every strobe exactly one of `res_ok`, `res_perm_err`, `res_rc_err` and `res_invalid` is high. After reset all four are low.
- R9: `res_attr` carries entry bits 5:4. The codes are 00 normal memory, 10 non-idempotent and 11 tolerant I/O; 01 is reserved and passed through unchanged.
- R10: `res_page_base` is entry bits 56:12 placed at bit 12 and up, with the low 12 bits zero.
- R11: During reset every output is driven to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_strobe | input | 1 | Starts a check of the current inputs |
| pte | input | 64 | Leaf page table entry |
| acc_priv | input | 1 | Access is privileged |
| acc_ifetch | input | 1 | Access is an instruction fetch |
| acc_store | input | 1 | Access is a store |
| res_ok | output | 1 | Translation may be installed |
| res_perm_err | output | 1 | Permission fault |
| res_rc_err | output | 1 | Reference/change fault |
| res_invalid | output | 1 | Entry not valid or not a leaf |
| res_attr | output | 2 | Memory attribute of the entry |
| res_page_base | output | 57 | Physical page base address |

## Verification
The verdict, the attribute and the page base are all due on the cycle after the edge that samples the strobe. Inputs are driven just after a falling edge, and each directed check reads the outputs at the next falling edge, which is half a period after the capture edge. A behavioural model updates only on sampled strobes and is compared at every falling edge. Between strobes the bench keeps changing `pte` and the access bits, so any output that moves without a strobe shows up as a mismatch.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

   // Little-endian positions of the permission-related entry bits
   localparam int unsigned BIT_EXEC  = 0;
   localparam int unsigned BIT_RW    = 1;
   localparam int unsigned BIT_RD    = 2;
   localparam int unsigned BIT_PRIV  = 3;
   localparam int unsigned ATTR_LO   = 4;
   localparam int unsigned BIT_CI    = 5;
   localparam int unsigned BIT_CHG   = 7;
   localparam int unsigned BIT_REF   = 8;

   typedef enum logic [1:0] {
      MA_NORMAL   = 2'b00,
      MA_RESERVED = 2'b01,
      MA_NONIDEM  = 2'b10,
      MA_TOLERANT = 2'b11
   } mem_attr_e;

   typedef struct packed {
      logic inval;
      logic perm_err;
      logic rc_err;
      logic ok;
   } verdict_t;

   typedef struct packed {
      logic valid;
      logic leaf;
      logic exec;
      logic rw;
      logic rd;
      logic priv_pg;
      logic ci;
      logic chg;
      logic refd;
   } pte_bits_t;

endpackage

// File: rtl/pte_field_decode.sv
module pte_field_decode
   import pte_chk_pkg::*;
#(
   parameter int PTE_W    = 64,
   parameter int PG_SHIFT = 12,
   localparam int RPN_HI  = PTE_W - 8,
   localparam int PA_W    = RPN_HI + 1
) (
   input  logic [PTE_W-1:0] pte,
   output pte_bits_t        bits,
   output mem_attr_e        attr,
   output logic [PA_W-1:0]  page_base
);

   if (PTE_W < 16) begin : g_bad_width
      $error("pte_field_decode: PTE_W too small");
   end
   if (PG_SHIFT <= BIT_REF || PG_SHIFT >= RPN_HI) begin : g_bad_shift
      $error("pte_field_decode: PG_SHIFT out of range");
   end

   always_comb begin
      bits.valid   = pte[PTE_W-1];
      bits.leaf    = pte[PTE_W-2];
      bits.exec    = pte[BIT_EXEC];
      bits.rw      = pte[BIT_RW];
      bits.rd      = pte[BIT_RD];
      bits.priv_pg = pte[BIT_PRIV];
      bits.ci      = pte[BIT_CI];
      bits.chg     = pte[BIT_CHG];
      bits.refd    = pte[BIT_REF];
      attr         = mem_attr_e'(pte[ATTR_LO +: 2]);
   end

   assign page_base = {pte[RPN_HI:PG_SHIFT], {PG_SHIFT{1'b0}}};

endmodule

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
   import pte_chk_pkg::*;
#(
   parameter bit CI_BLOCKS_EXEC = 1'b1
) (
   input  pte_bits_t bits,
   input  logic      acc_priv,
   input  logic      acc_ifetch,
   input  logic      acc_store,
   output verdict_t  verdict
);

   logic data_ok;
   logic fetch_ok;
   logic mode_ok;
   logic perm_ok;
   logic rc_ok;
   logic entry_ok;

   assign data_ok = bits.rw | (bits.rd & ~acc_store);

   if (CI_BLOCKS_EXEC) begin : g_ci_no_exec
      assign fetch_ok = bits.exec & ~bits.ci;
   end else begin : g_ci_exec
      assign fetch_ok = bits.exec;
   end

   always_comb begin
      entry_ok = bits.valid & bits.leaf;
      mode_ok  = acc_priv | ~bits.priv_pg;
      perm_ok  = mode_ok & (acc_ifetch ? fetch_ok : data_ok);
      rc_ok    = bits.refd & (bits.chg | ~acc_store);
      verdict          = '0;
      verdict.inval    = ~entry_ok;
      verdict.perm_err = entry_ok & ~perm_ok;
      verdict.rc_err   = entry_ok & perm_ok & ~rc_ok;
      verdict.ok       = entry_ok & perm_ok & rc_ok;
   end

endmodule

// File: rtl/pte_result_reg.sv
module pte_result_reg
   import pte_chk_pkg::*;
#(
   parameter int PA_W = 57
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  verdict_t        verdict_d,
   input  mem_attr_e       attr_d,
   input  logic [PA_W-1:0] base_d,
   output verdict_t        verdict_q,
   output mem_attr_e       attr_q,
   output logic [PA_W-1:0] base_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         verdict_q <= '0;
         attr_q    <= MA_NORMAL;
         base_q    <= '0;
      end else if (load) begin
         verdict_q <= verdict_d;
         attr_q    <= attr_d;
         base_q    <= base_d;
      end
   end

   // R8
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> $countones(verdict_q) == 1);

   // R1
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(verdict_q) && $stable(attr_q) && $stable(base_q)));

   // R7
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_q.perm_err |-> !verdict_q.rc_err);

   // R8
   flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(verdict_q));

endmodule

// File: rtl/pte_leaf_checker.sv
module pte_leaf_checker
   import pte_chk_pkg::*;
#(
   parameter int  PTE_W          = 64,
   parameter int  PG_SHIFT       = 12,
   parameter bit  CI_BLOCKS_EXEC = 1'b1,
   localparam int PA_W           = PTE_W - 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            chk_strobe,
   input  logic [PTE_W-1:0] pte,
   input  logic            acc_priv,
   input  logic            acc_ifetch,
   input  logic            acc_store,
   output logic            res_ok,
   output logic            res_perm_err,
   output logic            res_rc_err,
   output logic            res_invalid,
   output logic [1:0]      res_attr,
   output logic [PA_W-1:0] res_page_base
);

   pte_bits_t       bits;
   mem_attr_e       attr_c;
   mem_attr_e       attr_q;
   logic [PA_W-1:0] base_c;
   verdict_t        verdict_c;
   verdict_t        verdict_q;

   pte_field_decode #(.PTE_W(PTE_W), .PG_SHIFT(PG_SHIFT)) u_dec (
      .pte       (pte),
      .bits      (bits),
      .attr      (attr_c),
      .page_base (base_c)
   );

   pte_perm_eval #(.CI_BLOCKS_EXEC(CI_BLOCKS_EXEC)) u_eval (
      .bits       (bits),
      .acc_priv   (acc_priv),
      .acc_ifetch (acc_ifetch),
      .acc_store  (acc_store),
      .verdict    (verdict_c)
   );

   pte_result_reg #(.PA_W(PA_W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (chk_strobe),
      .verdict_d (verdict_c),
      .attr_d    (attr_c),
      .base_d    (base_c),
      .verdict_q (verdict_q),
      .attr_q    (attr_q),
      .base_q    (res_page_base)
   );

   assign res_ok       = verdict_q.ok;
   assign res_perm_err = verdict_q.perm_err;
   assign res_rc_err   = verdict_q.rc_err;
   assign res_invalid  = verdict_q.inval;
   assign res_attr     = attr_q;

   // R2
   invalid_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_strobe && !(pte[PTE_W-1] && pte[PTE_W-2]))
      |=> (res_invalid && !res_perm_err && !res_rc_err && !res_ok));

   // R3
   priv_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_strobe && pte[PTE_W-1] && pte[PTE_W-2] && pte[BIT_PRIV] && !acc_priv)
      |=> res_perm_err);

   // R4
   rw_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_strobe && pte[PTE_W-1] && pte[PTE_W-2] && !acc_ifetch && pte[BIT_RW]
       && (acc_priv || !pte[BIT_PRIV]))
      |=> !res_perm_err);

   // R5
   ci_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_strobe && pte[PTE_W-1] && pte[PTE_W-2] && acc_ifetch
       && (pte[BIT_CI] || !pte[BIT_EXEC]))
      |=> res_perm_err);

   // R6
   no_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_strobe && !pte[BIT_REF]) |=> !res_ok);

   // R9
   attr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_strobe |=> res_attr == $past(pte[ATTR_LO +: 2]));

   // R11
   reset_zero_chk: assert property (@(posedge clk)
      !rst_n |=> (!res_ok && !res_perm_err && !res_rc_err && !res_invalid
                  && res_attr == 2'b00));

endmodule

// File: tb/sim_pte_leaf_checker.sv
module sim_pte_leaf_checker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chk_strobe = 1'b0;
   logic [63:0] pte = '0;
   logic        acc_priv = 1'b0;
   logic        acc_ifetch = 1'b0;
   logic        acc_store = 1'b0;
   logic        res_ok, res_perm_err, res_rc_err, res_invalid;
   logic [1:0]  res_attr;
   logic [56:0] res_page_base;

   int checks = 0;
   int fails = 0;
   int clk_checks = 0;
   int clk_fails = 0;

   // model state
   logic [3:0]  m_flags = '0;   // {inval, perm, rc, ok}
   logic [1:0]  m_attr = '0;
   logic [56:0] m_base = '0;

   always #4 clk = ~clk;

   pte_leaf_checker u0 (
      .clk(clk), .rst_n(rst_n), .chk_strobe(chk_strobe), .pte(pte),
      .acc_priv(acc_priv), .acc_ifetch(acc_ifetch), .acc_store(acc_store),
      .res_ok(res_ok), .res_perm_err(res_perm_err), .res_rc_err(res_rc_err),
      .res_invalid(res_invalid), .res_attr(res_attr), .res_page_base(res_page_base)
   );

   function automatic logic [3:0] ref_flags(input logic [63:0] e, input logic p,
                                            input logic f, input logic s);
      logic allow;
      logic refchg;
      if (!e[63] || !e[62]) return 4'b1000;
      allow = 1'b0;
      if (p || !e[3]) begin
         if (f) allow = e[0] && !e[5];
         else   allow = e[1] || (e[2] && !s);
      end
      refchg = e[8] && (e[7] || !s);
      if (!allow)  return 4'b0100;
      if (!refchg) return 4'b0010;
      return 4'b0001;
   endfunction

   function automatic logic [56:0] ref_base(input logic [63:0] e);
      return e[56:0] & {{45{1'b1}}, 12'h000};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flags <= '0; m_attr <= '0; m_base <= '0;
      end else if (chk_strobe) begin
         m_flags <= ref_flags(pte, acc_priv, acc_ifetch, acc_store);
         m_attr  <= pte[5:4];
         m_base  <= ref_base(pte);
      end
   end

   // R1: cycle-by-cycle comparison with the model
   always @(negedge clk) begin
      if (rst_n) begin
         clk_checks++;
         if ({res_invalid, res_perm_err, res_rc_err, res_ok} != m_flags ||
             res_attr != m_attr || res_page_base != m_base) begin
            clk_fails++;
            $display("FAIL R1 cycle compare: got flags=%b attr=%b base=%h exp flags=%b attr=%b base=%h",
                     {res_invalid, res_perm_err, res_rc_err, res_ok}, res_attr, res_page_base,
                     m_flags, m_attr, m_base);
         end
      end
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drives one strobe, then checks flags at the next falling edge
   task automatic run(input string tag, input logic [63:0] e, input logic p,
                      input logic f, input logic s, input logic [3:0] exp);
      @(negedge clk);
      pte = e; acc_priv = p; acc_ifetch = f; acc_store = s; chk_strobe = 1'b1;
      @(negedge clk);
      chk_strobe = 1'b0;
      check(tag, {60'd0, res_invalid, res_perm_err, res_rc_err, res_ok}, {60'd0, exp});
   endtask

   localparam logic [63:0] VL = 64'hC000_0000_0000_0000;

   initial begin
      logic [63:0] lf;
      logic [3:0]  held;
      repeat (3) @(negedge clk);
      // R11
      check("R11 reset flags", {60'd0, res_invalid, res_perm_err, res_rc_err, res_ok}, 64'd0);
      check("R11 reset base", {7'd0, res_page_base}, 64'd0);
      rst_n = 1'b1;

      run("R4 load read-only", VL | 64'h104, 0, 0, 0, 4'b0001);
      run("R4 store read-only", VL | 64'h184, 0, 0, 1, 4'b0100);
      run("R4 store rw", VL | 64'h182, 0, 0, 1, 4'b0001);
      run("R4 no perm bits", VL | 64'h180, 0, 0, 0, 4'b0100);
      run("R6 store no change", VL | 64'h102, 0, 0, 1, 4'b0010);
      run("R6 load no ref", VL | 64'h082, 0, 0, 0, 4'b0010);
      run("R3 user on priv page", VL | 64'h18A, 0, 0, 1, 4'b0100);
      run("R3 priv on priv page", VL | 64'h18A, 1, 0, 1, 4'b0001);
      run("R5 fetch exec", VL | 64'h101, 0, 1, 0, 4'b0001);
      run("R5 fetch exec ci", VL | 64'h121, 0, 1, 0, 4'b0100);
      run("R5 fetch no exec", VL | 64'h106, 0, 1, 0, 4'b0100);
      run("R7 both fail", VL | 64'h004, 0, 0, 1, 4'b0100);
      run("R2 not valid", 64'h4000_0000_0000_0186, 1, 0, 0, 4'b1000);
      run("R2 not leaf", 64'h8000_0000_0000_0186, 1, 0, 0, 4'b1000);

      // R9 / R10
      run("R8 attr 10", VL | 64'h00AB_CDEF_1234_5126, 0, 0, 0, 4'b0001);
      check("R9 attr 10", {62'd0, res_attr}, 64'd2);
      check("R10 base", {7'd0, res_page_base}, 64'h00AB_CDEF_1234_5000);
      run("R8 attr 11", VL | 64'h0100_0000_0000_F13F, 1, 1, 0, 4'b0100);
      check("R9 attr 11", {62'd0, res_attr}, 64'd3);
      check("R10 base top", {7'd0, res_page_base}, 64'h0100_0000_0000_F000);

      // R1: inputs change with no strobe, outputs hold
      held = {res_invalid, res_perm_err, res_rc_err, res_ok};
      @(negedge clk);
      pte = 64'h0; acc_priv = 1; acc_ifetch = 0; acc_store = 0;
      repeat (3) @(negedge clk);
      check("R1 hold flags", {60'd0, res_invalid, res_perm_err, res_rc_err, res_ok}, {60'd0, held});
      check("R1 hold attr", {62'd0, res_attr}, 64'd3);

      // pseudo-random sweep against the model, strobe on some cycles
      lf = 64'h1234_5678_9ABC_DEF1;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
         pte = {lf[63:62] | {1'b0, lf[10]}, lf[61:0]};
         acc_priv = lf[20]; acc_ifetch = lf[21]; acc_store = lf[22];
         chk_strobe = lf[23] | lf[24];
      end
      @(negedge clk);
      chk_strobe = 1'b0;
      repeat (2) @(negedge clk);

      checks += clk_checks;
      fails += clk_fails;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      checks += clk_checks + 1;
      fails += clk_fails + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule